// File: doc/BRIEF.md
# Second-Operand Rotate and Shift Unit

This combinational unit forms the second operand of a 32-bit ALU together with the shifter carry that logical operations load into the carry flag. An operand field of 12 bits is interpreted one of two ways, chosen by a select input. In the constant form, an 8-bit value is rotated right by twice a 4-bit rotate count. In the register form, the value read from the operand register (supplied on `rm_val`) is shifted left or right logically, shifted right arithmetically, or rotated. A 33-bit rotate by one through the incoming carry is also available.

In the register form the shift distance is either a 5-bit constant held in the field or the low byte of a second register value (`rs_val`). The field encodings that a 5-bit constant cannot express directly (a right shift by the full word width, and the single-bit carry rotate) are reached through the zero codes of the constant distance. Distances between the word width and 255 from a register follow fixed saturation rules. The register indices inside the field are decoded by the register file, not here.

Top module: `barrel_opnd2`

## Requirements
- R1: With `use_imm`=1, `operand` equals the zero-extended constant `op_field[7:0]` rotated right by 2×`op_field[11:8]` places, and `rm_val`/`rs_val` have no effect.
- R2: With `use_imm`=1, `c_out` equals `c_in` when `op_field[11:8]`=0, and otherwise equals bit 31 of `operand`.
- R3: With `use_imm`=0, `op_field[6:5]` picks the kind (00 shift left, 01 logical shift right, 10 arithmetic shift right, 11 rotate right); `op_field[4]`=0 takes the distance from `op_field[11:7]`, `op_field[4]`=1 takes it from `rs_val[7:0]` only, ignoring `rs_val[31:8]`.
- R4: For a distance of 1 to 31, `operand` is the shifted or rotated `rm_val`, and `c_out` is the last bit moved out (for rotate right, bit 31 of `operand`).
- R5: A zero distance from the register, or a constant left shift of 0, gives `operand`=`rm_val` and `c_out`=`c_in`.
- R6: A constant distance code of 0 with logical shift right gives `operand`=0 and `c_out`=`rm_val[31]`; with arithmetic shift right it gives every bit equal to `rm_val[31]` and `c_out`=`rm_val[31]`.
- R7: A constant distance code of 0 with rotate right gives `operand`={`c_in`, `rm_val[31:1]`} and `c_out`=`rm_val[0]`.
- R8: A register distance of exactly 32 gives `operand`=0 for both left and logical right shifts, with `c_out`=`rm_val[0]` for the left shift and `rm_val[31]` for the right shift.
- R9: A register distance of 33 to 255 gives `operand`=0 and `c_out`=0 for left and logical right shifts; arithmetic right shift fills every bit with `rm_val[31]` and sets `c_out`=`rm_val[31]` for any distance of 32 or more.
- R10: A nonzero register distance with rotate right uses the distance modulo 32; when that remainder is 0, `operand`=`rm_val` and `c_out`=`rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| use_imm | input | 1 | 1 selects the rotated-constant form, 0 the register form |
| op_field | input | 12 | Operand field of the instruction |
| rm_val | input | 32 | Value of the operand register |
| rs_val | input | 32 | Value of the distance register; only the low byte is used |
| c_in | input | 1 | Current carry flag |
| operand | output | 32 | Second ALU operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The embedded checks assume that every input is a settled two-state value when they evaluate, since the unit has no clock of its own; the bench changes inputs only between clock edges and waits before sampling. They also assume that the register indices in the field carry no meaning for the unit, so the stimulus fills them with fixed values and places all significant information in the kind, distance and constant bits. The rotate sweep and the left-shift sweep exercise every rotate count and every in-range distance, while the table covers the saturation and zero-code encodings.

// File: rtl/bs_pkg.sv
`timescale 1ns/1ps
package bs_pkg;
   typedef enum logic [1:0] {
      SH_LSL = 2'b00,
      SH_LSR = 2'b01,
      SH_ASR = 2'b10,
      SH_ROR = 2'b11
   } shift_kind_e;
endpackage

// File: rtl/bs_imm_rotator.sv
`timescale 1ns/1ps
module bs_imm_rotator #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic [ROT_W-1:0]  rot,
   input  logic              c_in,
   output logic [DATA_W-1:0] val,
   output logic              c_out
);
   localparam int MAX_ROT = 2 * ((1 << ROT_W) - 1);

   generate
      if (MAX_ROT >= DATA_W) begin : g_bad_rot
         $error("rotate span exceeds the data width");
      end
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("constant wider than the data path");
      end
   endgenerate

   logic [DATA_W-1:0]   zext;
   logic [2*DATA_W-1:0] doubled;

   always_comb begin
      zext    = {{(DATA_W-IMM_W){1'b0}}, imm};
      doubled = {zext, zext} >> {rot, 1'b0};
      val     = doubled[DATA_W-1:0];
      c_out   = (rot == '0) ? c_in : doubled[DATA_W-1];
   end

   // R1: a rotation keeps the number of set bits
   always_comb begin
      p_rot_bits_r1: assert ($countones(val) == $countones(imm))
         else $error("rotated constant lost or gained bits");
   end
endmodule

// File: rtl/bs_amount_select.sv
`timescale 1ns/1ps
module bs_amount_select
   import bs_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int AMT_W   = 8,
   parameter int SHIMM_W = 5
) (
   input  logic               from_reg,
   input  shift_kind_e        kind,
   input  logic [SHIMM_W-1:0] imm_amt,
   input  logic [AMT_W-1:0]   reg_amt,
   output logic [AMT_W-1:0]   amt,
   output logic               rrx
);
   generate
      if ((1 << AMT_W) <= DATA_W) begin : g_bad_amt
         $error("distance width cannot hold the word width");
      end
      if (SHIMM_W > AMT_W) begin : g_bad_shimm
         $error("constant distance wider than register distance");
      end
   endgenerate

   localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

   always_comb begin
      rrx = 1'b0;
      amt = '0;
      if (from_reg) begin
         amt = reg_amt;
      end else if (imm_amt != '0) begin
         amt = {{(AMT_W-SHIMM_W){1'b0}}, imm_amt};
      end else begin
         unique case (kind)
            SH_LSL: amt = '0;
            SH_LSR: amt = FULL;
            SH_ASR: amt = FULL;
            SH_ROR: rrx = 1'b1;
            default: amt = '0;
         endcase
      end
   end

   // R7: the carry-rotate request only comes from the constant form
   always_comb begin
      p_rrx_src_r7: assert (!(rrx && from_reg))
         else $error("carry rotate selected for a register distance");
   end
endmodule

// File: rtl/bs_shift_core.sv
`timescale 1ns/1ps
module bs_shift_core
   import bs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8
) (
   input  logic [DATA_W-1:0] val,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              rrx,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);
   localparam int SH_W = $clog2(DATA_W);
   localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

   generate
      if ((1 << SH_W) != DATA_W) begin : g_bad_pow2
         $error("data width must be a power of two");
      end
   endgenerate

   logic [SH_W-1:0]        low;
   logic                   in_range;
   logic [DATA_W:0]        lsl_w;
   logic [DATA_W:0]        lsr_w;
   logic signed [DATA_W:0] asr_src;
   logic signed [DATA_W:0] asr_w;
   logic [2*DATA_W-1:0]    ror_w;

   always_comb begin
      low      = amt[SH_W-1:0];
      in_range = (amt < FULL);
      lsl_w    = {1'b0, val} << low;
      lsr_w    = {val, 1'b0} >> low;
      asr_src  = {val, 1'b0};
      asr_w    = asr_src >>> low;
      ror_w    = {val, val} >> low;
   end

   always_comb begin
      res   = val;
      c_out = c_in;
      if (rrx) begin
         res   = {c_in, val[DATA_W-1:1]};
         c_out = val[0];
      end else if (amt != '0) begin
         unique case (kind)
            SH_LSL: begin
               if (in_range) begin
                  res   = lsl_w[DATA_W-1:0];
                  c_out = lsl_w[DATA_W];
               end else begin
                  res   = '0;
                  c_out = (amt == FULL) ? val[0] : 1'b0;
               end
            end
            SH_LSR: begin
               if (in_range) begin
                  res   = lsr_w[DATA_W:1];
                  c_out = lsr_w[0];
               end else begin
                  res   = '0;
                  c_out = (amt == FULL) ? val[DATA_W-1] : 1'b0;
               end
            end
            SH_ASR: begin
               if (in_range) begin
                  res   = asr_w[DATA_W:1];
                  c_out = asr_w[0];
               end else begin
                  res   = {DATA_W{val[DATA_W-1]}};
                  c_out = val[DATA_W-1];
               end
            end
            SH_ROR: begin
               res   = ror_w[DATA_W-1:0];
               c_out = ror_w[DATA_W-1];
            end
            default: begin
               res   = val;
               c_out = c_in;
            end
         endcase
      end
   end

   // R9: logical shifts beyond the word width clear both result and carry
   always_comb begin
      if (!rrx && amt > FULL && (kind == SH_LSL || kind == SH_LSR))
         p_wide_logical_r9: assert (res == '0 && !c_out)
            else $error("wide logical shift left residue");
   end

   // R9: arithmetic shifts at or beyond the width replicate the sign
   always_comb begin
      if (!rrx && amt >= FULL && kind == SH_ASR)
         p_sign_fill_r9: assert (res == {DATA_W{val[DATA_W-1]}} && c_out == val[DATA_W-1])
            else $error("arithmetic shift did not saturate to the sign");
   end

   // R7: carry rotate moves the low bit to the carry and the carry to the top
   always_comb begin
      if (rrx)
         p_rrx_move_r7: assert (c_out == val[0] && res[DATA_W-1] == c_in)
            else $error("carry rotate mismatch");
   end

   // R10: a rotate keeps the number of set bits
   always_comb begin
      if (!rrx && kind == SH_ROR)
         p_ror_bits_r10: assert ($countones(res) == $countones(val))
            else $error("rotate changed the bit count");
   end
endmodule

// File: rtl/barrel_opnd2.sv
`timescale 1ns/1ps
module barrel_opnd2
   import bs_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int IMM_W   = 8,
   parameter int ROT_W   = 4,
   parameter int IDX_W   = 4,
   parameter int SHIMM_W = 5,
   parameter int AMT_W   = 8,
   parameter int FIELD_W = 12
) (
   input  logic               use_imm,
   input  logic [FIELD_W-1:0] op_field,
   input  logic [DATA_W-1:0]  rm_val,
   input  logic [DATA_W-1:0]  rs_val,
   input  logic               c_in,
   output logic [DATA_W-1:0]  operand,
   output logic               c_out
);
   localparam int ROT_LSB   = IMM_W;
   localparam int SRC_BIT   = IDX_W;
   localparam int KIND_LSB  = IDX_W + 1;
   localparam int SHIMM_LSB = KIND_LSB + 2;

   generate
      if (IMM_W + ROT_W != FIELD_W) begin : g_bad_imm_layout
         $error("constant layout does not fill the field");
      end
      if (SHIMM_LSB + SHIMM_W != FIELD_W) begin : g_bad_reg_layout
         $error("register layout does not fill the field");
      end
   endgenerate

   logic [IMM_W-1:0]   imm8;
   logic [ROT_W-1:0]   rot;
   logic               from_reg;
   shift_kind_e        kind;
   logic [SHIMM_W-1:0] imm_amt;
   logic [DATA_W-1:0]  imm_val;
   logic               imm_c;
   logic [AMT_W-1:0]   amt;
   logic               rrx;
   logic [DATA_W-1:0]  sh_res;
   logic               sh_c;
   logic               unused_bits;

   assign imm8        = op_field[IMM_W-1:0];
   assign rot         = op_field[ROT_LSB +: ROT_W];
   assign from_reg    = op_field[SRC_BIT];
   assign kind        = shift_kind_e'(op_field[KIND_LSB +: 2]);
   assign imm_amt     = op_field[SHIMM_LSB +: SHIMM_W];
   assign unused_bits = ^{op_field[IDX_W-1:0], rs_val[DATA_W-1:AMT_W]};

   bs_imm_rotator #(
      .DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)
   ) i_rot (
      .imm(imm8), .rot(rot), .c_in(c_in), .val(imm_val), .c_out(imm_c)
   );

   bs_amount_select #(
      .DATA_W(DATA_W), .AMT_W(AMT_W), .SHIMM_W(SHIMM_W)
   ) i_amt (
      .from_reg(from_reg), .kind(kind), .imm_amt(imm_amt),
      .reg_amt(rs_val[AMT_W-1:0]), .amt(amt), .rrx(rrx)
   );

   bs_shift_core #(
      .DATA_W(DATA_W), .AMT_W(AMT_W)
   ) i_core (
      .val(rm_val), .kind(kind), .amt(amt), .rrx(rrx), .c_in(c_in),
      .res(sh_res), .c_out(sh_c)
   );

   always_comb begin
      operand = use_imm ? imm_val : sh_res;
      c_out   = use_imm ? imm_c   : sh_c;
   end

   // R2: a zero rotate count leaves the carry alone
   always_comb begin
      if (use_imm && rot == '0)
         p_imm_keep_c_r2: assert (c_out == c_in)
            else $error("constant with zero rotate altered the carry");
   end

   // R5: constant left shift of zero passes the register through
   always_comb begin
      if (!use_imm && !from_reg && kind == SH_LSL && imm_amt == '0)
         p_lsl0_pass_r5: assert (operand == rm_val && c_out == c_in)
            else $error("zero left shift changed operand or carry");
   end

   // R6: constant logical right code zero yields an empty operand
   always_comb begin
      if (!use_imm && !from_reg && kind == SH_LSR && imm_amt == '0)
         p_lsr0_full_r6: assert (operand == '0 && c_out == rm_val[DATA_W-1])
            else $error("logical right zero code did not shift the full width");
   end
endmodule

// File: tb/test_barrel_opnd2.sv
`timescale 1ns/1ps
module test_barrel_opnd2;
   typedef struct packed {
      logic [3:0]  tag;
      logic        imm;
      logic [11:0] fld;
      logic [31:0] rm;
      logic [31:0] rs;
      logic        ci;
      logic [31:0] eo;
      logic        ec;
   } vec_t;

   function automatic logic [11:0] fimm(input logic [3:0] r, input logic [7:0] k);
      return {r, k};
   endfunction
   function automatic logic [11:0] fsi(input logic [4:0] a, input logic [1:0] t);
      return {a, t, 1'b0, 4'h3};
   endfunction
   function automatic logic [11:0] fsr(input logic [1:0] t);
      return {4'h5, 1'b0, t, 1'b1, 4'h3};
   endfunction
   function automatic vec_t mk(input logic [3:0] tag, input logic imm, input logic [11:0] f,
                               input logic [31:0] rm, input logic [31:0] rs, input logic ci,
                               input logic [31:0] eo, input logic ec);
      return '{tag, imm, f, rm, rs, ci, eo, ec};
   endfunction

   localparam int NV = 30;
   localparam vec_t VEC [NV] = '{
      mk(1,  1, fimm(4'h4, 8'hFF), 32'hF0F01234, 32'h12345678, 0, 32'hFF000000, 1), // R1
      mk(1,  1, fimm(4'h1, 8'h03), 32'h0,        32'h0,        0, 32'hC0000000, 1), // R1
      mk(2,  1, fimm(4'h0, 8'hAB), 32'hFFFFFFFF, 32'h0,        1, 32'h000000AB, 1), // R2
      mk(2,  1, fimm(4'hF, 8'h01), 32'h0,        32'h0,        1, 32'h00000004, 0), // R2
      mk(4,  0, fsi(5'd4, 2'b00),  32'hF0F01234, 32'h0,        0, 32'h0F012340, 1), // R4
      mk(4,  0, fsi(5'd4, 2'b01),  32'hF0F01234, 32'h0,        1, 32'h0F0F0123, 0), // R4
      mk(4,  0, fsi(5'd4, 2'b10),  32'hF0F01234, 32'h0,        1, 32'hFF0F0123, 0), // R4
      mk(4,  0, fsi(5'd8, 2'b11),  32'hF0F01234, 32'h0,        1, 32'h34F0F012, 0), // R4
      mk(4,  0, fsi(5'd31, 2'b00), 32'h80000003, 32'h0,        0, 32'h80000000, 1), // R4
      mk(4,  0, fsi(5'd31, 2'b01), 32'h80000003, 32'h0,        1, 32'h00000001, 0), // R4
      mk(4,  0, fsr(2'b10),        32'h80000001, 32'h00000001, 0, 32'hC0000000, 1), // R4
      mk(5,  0, fsi(5'd0, 2'b00),  32'h80000001, 32'h0,        1, 32'h80000001, 1), // R5
      mk(5,  0, fsr(2'b01),        32'h80000001, 32'h00000100, 0, 32'h80000001, 0), // R5
      mk(6,  0, fsi(5'd0, 2'b01),  32'h80000001, 32'h0,        0, 32'h00000000, 1), // R6
      mk(6,  0, fsi(5'd0, 2'b10),  32'h80000001, 32'h0,        0, 32'hFFFFFFFF, 1), // R6
      mk(6,  0, fsi(5'd0, 2'b10),  32'h40000002, 32'h0,        1, 32'h00000000, 0), // R6
      mk(7,  0, fsi(5'd0, 2'b11),  32'h80000001, 32'h0,        0, 32'h40000000, 1), // R7
      mk(7,  0, fsi(5'd0, 2'b11),  32'h40000002, 32'h0,        1, 32'hA0000001, 0), // R7
      mk(3,  0, fsr(2'b00),        32'hF0F01234, 32'hFFFFFF04, 0, 32'h0F012340, 1), // R3
      mk(3,  0, fsr(2'b11),        32'hF0F01234, 32'hABCDEF08, 1, 32'h34F0F012, 0), // R3
      mk(8,  0, fsr(2'b00),        32'h80000001, 32'h00000020, 0, 32'h00000000, 1), // R8
      mk(8,  0, fsr(2'b00),        32'h40000002, 32'h00000020, 1, 32'h00000000, 0), // R8
      mk(8,  0, fsr(2'b01),        32'h80000001, 32'h00000020, 0, 32'h00000000, 1), // R8
      mk(9,  0, fsr(2'b00),        32'hFFFFFFFF, 32'h00000021, 1, 32'h00000000, 0), // R9
      mk(9,  0, fsr(2'b01),        32'hFFFFFFFF, 32'h000000C8, 1, 32'h00000000, 0), // R9
      mk(9,  0, fsr(2'b10),        32'h80000001, 32'h00000028, 0, 32'hFFFFFFFF, 1), // R9
      mk(9,  0, fsr(2'b10),        32'h40000002, 32'h000000FF, 1, 32'h00000000, 0), // R9
      mk(10, 0, fsr(2'b11),        32'h80000001, 32'h00000020, 0, 32'h80000001, 1), // R10
      mk(10, 0, fsr(2'b11),        32'hF0F01234, 32'h00000024, 1, 32'h4F0F0123, 0), // R10
      mk(10, 0, fsr(2'b11),        32'h40000002, 32'h00000040, 1, 32'h40000002, 0)  // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        use_imm;
   logic [11:0] op_field;
   logic [31:0] rm_val, rs_val, operand;
   logic        c_in, c_out;
   int          n_vec = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   barrel_opnd2 i_barrel_opnd2 (
      .use_imm(use_imm), .op_field(op_field), .rm_val(rm_val), .rs_val(rs_val),
      .c_in(c_in), .operand(operand), .c_out(c_out)
   );

   task automatic apply(input int tag, input logic imm, input logic [11:0] f,
                        input logic [31:0] rm, input logic [31:0] rs, input logic ci,
                        input logic [31:0] eo, input logic ec);
      @(negedge clk);
      use_imm = imm; op_field = f; rm_val = rm; rs_val = rs; c_in = ci;
      #2;
      n_vec++;
      if (operand !== eo || c_out !== ec) begin
         n_bad++;
         $display("FAIL R%0d: field=%h operand=%h carry=%b expected operand=%h carry=%b",
                  tag, f, operand, c_out, eo, ec);
      end
   endtask

   initial begin
      use_imm = 1'b0; op_field = '0; rm_val = '0; rs_val = '0; c_in = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs give a zero operand and carry (R5)
      apply(5, 0, 12'h000, 32'h0, 32'h0, 0, 32'h0, 0);
      foreach (VEC[i])
         apply(VEC[i].tag, VEC[i].imm, VEC[i].fld, VEC[i].rm, VEC[i].rs, VEC[i].ci,
               VEC[i].eo, VEC[i].ec);
      // R1 and R2: every rotate count on a two-bit constant
      for (int r = 0; r < 16; r++) begin
         logic [63:0] d;
         logic [31:0] e;
         d = {32'h81, 32'h81} >> (2 * r);
         e = d[31:0];
         apply(1, 1, fimm(4'(r), 8'h81), 32'hDEADBEEF, 32'h0, 1, e, (r == 0) ? 1'b1 : e[31]);
      end
      // R4: every in-range left-shift distance from the register
      for (int a = 1; a < 32; a++) begin
         logic [31:0] v;
         v = 32'hF0F01234;
         apply(4, 0, fsr(2'b00), v, 32'(a), 0, v << a, v[32-a]);
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule